// File: doc/BRIEF.md
# APB Programmable Down-Counter Timer

This block is one timer channel behind an APB slave. Firmware programs it entirely through the bus. It holds a period value in a reload register and keeps a separate live down-counter. A prescaler produces a one-cycle tick-enable that paces each decrement. A control word sets the enable, the counting mode, the divider, the counter width and the interrupt mask.

When a tick lands while the count is zero, the counter does one of three things. In one-shot mode it stays at zero. In periodic mode it restarts from the reload register. In free-running mode it wraps to all-ones. The same event sets a raw interrupt latch. The latch is masked onto the interrupt pin, and any write to a clear register empties it.

The period can be changed in two ways. The direct load replaces the live count at once and restarts the current interval. The background load changes only the reload register, so the interval already in progress ends at its original length.

Each cycle, the counter path picks one named action from a combinational decode. A single register process then applies it. The actions are:

- ACT_FORCE: a load write.
- ACT_IDLE: no tick.
- ACT_DEC: a tick with a non-zero count.
- ACT_HOLD: a tick at zero in one-shot mode.
- ACT_RELOAD: a tick at zero in periodic mode.
- ACT_WRAP: a tick at zero in free-running mode.

The priority runs in the order ACT_FORCE, ACT_IDLE, ACT_DEC, then one of ACT_HOLD, ACT_RELOAD and ACT_WRAP chosen by the mode bits.

Top module: `apb_countdown_timer`

## Requirements
- R1: After reset the registers read as follows: control 0x20, live value 0xFFFFFFFF, and 0 for the reload register, raw status and masked status. The interrupt output is low.
- R2: A register write takes effect only on a clock edge where psel, penable and pwrite are all high. The register offsets are:
  - 0x00: load (read/write)
  - 0x04: live value (read-only)
  - 0x08: control (read/write)
  - 0x0C: clear (write-only, reads 0)
  - 0x10: raw status (bit 0)
  - 0x14: masked status (bit 0)
  - 0x18: background load (reads the reload register)

  Any other offset reads 0. pready is always 1 and pslverr always 0.
- R3: A write to offset 0x00 sets the reload register, and on the next clock it also replaces the live count. A running period therefore restarts from the written value.
- R4: A write to offset 0x18 sets only the reload register. The live count keeps running and the current period keeps its length. The new value first takes effect at the next reload.
- R5: When control bit 1 is 0 (16-bit width), a written load value keeps only its low 16 bits. When bit 1 is 1, all 32 bits are kept.
- R6: Control bits 3:2 select the number of clocks per decrement: 00 gives 1, 01 gives 16, and both 10 and 11 give 256. The divider only gates the decrement, never the clock. With control bit 7 (enable) low, there are no ticks, the live count is frozen and the divider count is held at zero.
- R7: At a tick with the count at zero, the counter behaves as follows:
  - If control bit 0 (one-shot) is set, it holds at zero, overriding the mode bit.
  - Otherwise, if control bit 6 is 1 (periodic), it reloads from the reload register.
  - Otherwise it wraps to 0xFFFF or 0xFFFFFFFF, according to the width.
- R8: A tick at zero sets the raw interrupt latch. Masked status is raw AND control bit 5, and the interrupt output equals masked status.
- R9: Any write to offset 0x0C clears the raw latch, whatever the data. It wins over a zero tick in the same cycle. Reading any register never clears the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and timer clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid while the access is selected |
| pready | output | 1 | Always 1, no wait states |
| pslverr | output | 1 | Always 0 |
| tmr_irq | output | 1 | Masked interrupt |

## Verification
The first interrupt delay after enable is measured for each divider code with chosen load values. A latency of L+1, 16(L+1) or 256(L+1) cycles distinguishes a correct divider from one that is off by one or that ignores the 11 code. A periodic timer is retuned mid-count by both paths:

- With the background load, the first interrupt still comes at the old period and the next at the new one.
- With the direct load, the count restarts immediately.

Between them, the two cases tell a period-preserving design from a glitching one. The one-shot case (with the periodic bit also set) and the 16-bit free-running wrap separate the three zero-tick actions. They also show raw status set while masked status stays low.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Register offsets inside the channel (firmware-visible map)
    localparam int OFS_LOAD   = 'h00;
    localparam int OFS_VALUE  = 'h04;
    localparam int OFS_CTRL   = 'h08;
    localparam int OFS_CLEAR  = 'h0C;
    localparam int OFS_RAW    = 'h10;
    localparam int OFS_MASKED = 'h14;
    localparam int OFS_BGLOAD = 'h18;

    // Control word; member order fixes bit positions 7..0
    typedef struct packed {
        logic       run;       // bit 7 enable
        logic       periodic;  // bit 6 1 = reload at zero
        logic       irq_en;    // bit 5 interrupt mask
        logic       spare;     // bit 4 stored, no function
        logic [1:0] div;       // bits 3:2 divider select
        logic       wide;      // bit 1 1 = 32-bit
        logic       single;    // bit 0 one-shot
    } ctrl_t;

    localparam logic [7:0] CTRL_RESET = 8'h20;

    // Per-cycle counter action
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_FORCE,
        ACT_DEC,
        ACT_HOLD,
        ACT_RELOAD,
        ACT_WRAP
    } act_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV_MID  = 16,
    parameter int DIV_HIGH = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [1:0] div_i,
    output logic       tick_o
);
    localparam int PW = $clog2(DIV_HIGH);

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] limit;

    always_comb begin
        unique case (div_i)
            2'b00:   limit = '0;
            2'b01:   limit = PW'(DIV_MID - 1);
            default: limit = PW'(DIV_HIGH - 1);  // 10 and 11
        endcase
    end

    assign tick_o = run_i && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (!run_i)          cnt_q <= '0;
        else if (cnt_q == limit)  cnt_q <= '0;
        else                      cnt_q <= cnt_q + PW'(1);
    end
endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             force_i,
    input  logic [CNT_W-1:0] force_val_i,
    input  logic             tick_i,
    input  logic             single_i,
    input  logic             periodic_i,
    input  logic             wide_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             zero_evt_o
);
    localparam int HALF = CNT_W / 2;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] wrap_val;
    logic             at_zero;
    act_e             act;

    assign at_zero  = (count_q == '0);
    assign wrap_val = wide_i ? {CNT_W{1'b1}} : {{(CNT_W-HALF){1'b0}}, {HALF{1'b1}}};

    // Action decode
    always_comb begin
        if (force_i)           act = ACT_FORCE;
        else if (!tick_i)      act = ACT_IDLE;
        else if (!at_zero)     act = ACT_DEC;
        else if (single_i)     act = ACT_HOLD;
        else if (periodic_i)   act = ACT_RELOAD;
        else                   act = ACT_WRAP;
    end

    // Count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '1;
        end else begin
            unique case (act)
                ACT_FORCE:  count_q <= force_val_i;
                ACT_DEC:    count_q <= count_q - CNT_W'(1);
                ACT_RELOAD: count_q <= reload_i;
                ACT_WRAP:   count_q <= wrap_val;
                default:    count_q <= count_q;   // ACT_IDLE, ACT_HOLD
            endcase
        end
    end

    assign count_o    = count_q;
    assign zero_evt_o = tick_i && at_zero;
endmodule

// File: rtl/tmr_irq_latch.sv
module tmr_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic mask_i,
    output logic raw_o,
    output logic masked_o
);
    logic raw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      raw_q <= 1'b0;
        else if (clr_i)  raw_q <= 1'b0;   // clear beats a same-cycle set
        else if (set_i)  raw_q <= 1'b1;
    end

    assign raw_o    = raw_q;
    assign masked_o = raw_q & mask_i;
endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] count_i,
    input  logic              raw_i,
    input  logic              masked_i,
    output ctrl_t             ctrl_o,
    output logic [DATA_W-1:0] reload_o,
    output logic              wr_load_o,
    output logic              wr_clr_o,
    output logic [DATA_W-1:0] wval_o,
    output logic [DATA_W-1:0] prdata
);
    localparam int HALF = DATA_W / 2;
    localparam logic [ADDR_W-1:0] A_LOAD   = ADDR_W'(OFS_LOAD);
    localparam logic [ADDR_W-1:0] A_VALUE  = ADDR_W'(OFS_VALUE);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);
    localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);
    localparam logic [ADDR_W-1:0] A_BGLOAD = ADDR_W'(OFS_BGLOAD);

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] reload_q;
    logic              wr;
    logic              wr_load, wr_bg, wr_ctrl;
    logic [DATA_W-1:0] wval;

    assign wr      = psel && penable && pwrite;
    assign wr_load = wr && (paddr == A_LOAD);
    assign wr_bg   = wr && (paddr == A_BGLOAD);
    assign wr_ctrl = wr && (paddr == A_CTRL);

    // Width masking of written period values
    assign wval = ctrl_q.wide ? pwdata : {{(DATA_W-HALF){1'b0}}, pwdata[HALF-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ctrl_q <= ctrl_t'(CTRL_RESET);
        else if (wr_ctrl)  ctrl_q <= ctrl_t'(pwdata[7:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 reload_q <= '0;
        else if (wr_load || wr_bg)  reload_q <= wval;
    end

    // Read mux
    always_comb begin
        unique case (paddr)
            A_LOAD,
            A_BGLOAD: prdata = reload_q;
            A_VALUE:  prdata = count_i;
            A_CTRL:   prdata = DATA_W'(ctrl_q);
            A_RAW:    prdata = DATA_W'(raw_i);
            A_MASKED: prdata = DATA_W'(masked_i);
            default:  prdata = '0;   // clear register and unmapped space
        endcase
    end

    assign ctrl_o    = ctrl_q;
    assign reload_o  = reload_q;
    assign wr_load_o = wr_load;
    assign wr_clr_o  = wr && (paddr == A_CLEAR);
    assign wval_o    = wval;
endmodule

// File: rtl/apb_countdown_timer.sv
module apb_countdown_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int DIV_MID  = 16,
    parameter int DIV_HIGH = 256
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              tmr_irq
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] wval;
    logic              wr_load, wr_clr;
    logic              tick, zero_evt;
    logic              ris_q, mis;

    tmr_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(pclk), .rst_n(presetn),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata),
        .count_i(count_q), .raw_i(ris_q), .masked_i(mis),
        .ctrl_o(ctrl_q), .reload_o(reload_q),
        .wr_load_o(wr_load), .wr_clr_o(wr_clr),
        .wval_o(wval), .prdata(prdata)
    );

    tmr_prescaler #(.DIV_MID(DIV_MID), .DIV_HIGH(DIV_HIGH)) u_pre (
        .clk(pclk), .rst_n(presetn),
        .run_i(ctrl_q.run), .div_i(ctrl_q.div), .tick_o(tick)
    );

    tmr_downcount #(.CNT_W(DATA_W)) u_cnt (
        .clk(pclk), .rst_n(presetn),
        .force_i(wr_load), .force_val_i(wval),
        .tick_i(tick), .single_i(ctrl_q.single),
        .periodic_i(ctrl_q.periodic), .wide_i(ctrl_q.wide),
        .reload_i(reload_q), .count_o(count_q), .zero_evt_o(zero_evt)
    );

    tmr_irq_latch u_irq (
        .clk(pclk), .rst_n(presetn),
        .set_i(zero_evt), .clr_i(wr_clr), .mask_i(ctrl_q.irq_en),
        .raw_o(ris_q), .masked_o(mis)
    );

    assign tmr_irq = mis;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              pclk,
    input logic              presetn,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic              tmr_irq,
    input ctrl_t             ctrl_q,
    input logic [DATA_W-1:0] reload_q,
    input logic [DATA_W-1:0] count_q,
    input logic              ris_q,
    input logic              tick
);
    localparam int HALF = DATA_W / 2;

    logic              c_wr, c_load, c_bg, c_clr, c_ctrl, c_zero;
    logic [DATA_W-1:0] c_mask;

    assign c_wr   = psel && penable && pwrite;
    assign c_load = c_wr && (paddr == ADDR_W'(OFS_LOAD));
    assign c_bg   = c_wr && (paddr == ADDR_W'(OFS_BGLOAD));
    assign c_clr  = c_wr && (paddr == ADDR_W'(OFS_CLEAR));
    assign c_ctrl = c_wr && (paddr == ADDR_W'(OFS_CTRL));
    assign c_zero = tick && (count_q == '0);
    assign c_mask = ctrl_q.wide ? {DATA_W{1'b1}} : {{(DATA_W-HALF){1'b0}}, {HALF{1'b1}}};

    AST_CTRL_HELD: assert property (@(posedge pclk) disable iff (!presetn)
        !c_ctrl |=> $stable(ctrl_q)); // R2
    AST_LOAD_FORCE: assert property (@(posedge pclk) disable iff (!presetn)
        c_load |=> count_q == $past(pwdata & c_mask)); // R3
    AST_BG_RELOAD_ONLY: assert property (@(posedge pclk) disable iff (!presetn)
        (c_bg && !tick) |=> $stable(count_q)); // R4
    AST_BG_SETS_RELOAD: assert property (@(posedge pclk) disable iff (!presetn)
        c_bg |=> reload_q == $past(pwdata & c_mask)); // R4
    AST_HALF_WIDTH: assert property (@(posedge pclk) disable iff (!presetn)
        (c_load && !ctrl_q.wide) |=> count_q[DATA_W-1:HALF] == '0); // R5
    AST_IDLE_FREEZE: assert property (@(posedge pclk) disable iff (!presetn)
        (!ctrl_q.run && !c_load) |=> $stable(count_q)); // R6
    AST_ONESHOT_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
        (c_zero && ctrl_q.single && !c_load) |=> count_q == '0); // R7
    AST_PERIODIC_RELOAD: assert property (@(posedge pclk) disable iff (!presetn)
        (c_zero && !ctrl_q.single && ctrl_q.periodic && !c_load)
        |=> count_q == $past(reload_q)); // R7
    AST_FREE_WRAP: assert property (@(posedge pclk) disable iff (!presetn)
        (c_zero && !ctrl_q.single && !ctrl_q.periodic && !c_load)
        |=> count_q == $past(c_mask)); // R7
    AST_ZERO_SETS_RAW: assert property (@(posedge pclk) disable iff (!presetn)
        (c_zero && !c_clr) |=> ris_q); // R8
    AST_MASK_BLOCKS: assert property (@(posedge pclk) disable iff (!presetn)
        !ctrl_q.irq_en |-> !tmr_irq); // R8
    AST_CLEAR_WINS: assert property (@(posedge pclk) disable iff (!presetn)
        c_clr |=> (!ris_q && !tmr_irq)); // R9
    AST_RAW_STICKY: assert property (@(posedge pclk) disable iff (!presetn)
        (ris_q && !c_clr) |=> ris_q); // R9
endmodule

bind apb_countdown_timer tmr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .tmr_irq(tmr_irq),
    .ctrl_q(ctrl_q), .reload_q(reload_q), .count_q(count_q),
    .ris_q(ris_q), .tick(tick)
);

// File: tb/tb_apb_countdown_timer.sv
module tb_apb_countdown_timer;
    localparam int AW = 8;
    localparam int DW = 32;

    localparam logic [7:0] A_LOAD = 8'h00, A_VAL = 8'h04, A_CTL = 8'h08, A_CLR = 8'h0C;
    localparam logic [7:0] A_RAW  = 8'h10, A_MSK = 8'h14, A_BG  = 8'h18;
    // control bit values
    localparam logic [31:0] EN = 32'h80, PER = 32'h40, IE = 32'h20, WIDE = 32'h02, ONE = 32'h01;

    logic          pclk = 1'b0;
    logic          presetn = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0;
    logic [DW-1:0] prdata;
    logic          pready, pslverr, tmr_irq;

    int unsigned checks = 0;
    int unsigned errors = 0;
    int unsigned cyc = 0;
    logic        irq_prev = 1'b0;

    // scoreboard queues
    logic [31:0] rd_exp_q[$];
    string       rd_tag_q[$];
    logic [31:0] irq_exp_q[$];
    string       irq_tag_q[$];

    apb_countdown_timer dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .tmr_irq(tmr_irq)
    );

    always #2 pclk = ~pclk;   // 250 MHz
    always @(posedge pclk) cyc <= cyc + 1;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items as results appear
    always @(negedge pclk) begin
        if (psel && penable && !pwrite) begin
            if (rd_exp_q.size() == 0) begin
                check(prdata, 32'hDEAD_BEEF, "R2 read without expectation");
            end else begin
                check(prdata, rd_exp_q.pop_front(), rd_tag_q.pop_front());
            end
        end
        if (tmr_irq && !irq_prev && irq_exp_q.size() != 0)
            check(cyc, irq_exp_q.pop_front(), irq_tag_q.pop_front());
        irq_prev = tmr_irq;
    end

    task automatic apb_write_at(input logic [7:0] a, input logic [31:0] d, output int unsigned at);
        @(posedge pclk); #1;
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(posedge pclk); #1;
        penable = 1'b1;
        @(posedge pclk); #1;
        at = cyc;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
        int unsigned dummy;
        apb_write_at(a, d, dummy);
    endtask

    task automatic expect_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        rd_exp_q.push_back(exp);
        rd_tag_q.push_back(tag);
        @(posedge pclk); #1;
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(posedge pclk); #1;
        penable = 1'b1;
        @(posedge pclk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic expect_irq(input int unsigned at, input string tag);
        irq_exp_q.push_back(at);
        irq_tag_q.push_back(tag);
    endtask

    task automatic wait_irq_done();
        while (irq_exp_q.size() != 0) @(negedge pclk);
    endtask

    // one prescale trial: first interrupt comes latency cycles after enable
    task automatic div_trial(input logic [31:0] divbits, input logic [31:0] ld,
                             input int unsigned latency, input string tag);
        int unsigned e;
        apb_write(A_CTL, IE | WIDE);
        apb_write(A_CLR, 32'h1);
        apb_write(A_LOAD, ld);
        apb_write_at(A_CTL, EN | PER | IE | WIDE | divbits, e);
        expect_irq(e + latency, tag);
        wait_irq_done();
        apb_write(A_CTL, IE | WIDE);
        apb_write(A_CLR, 32'h1);
    endtask

    task automatic finish_run();
        check(rd_exp_q.size() + irq_exp_q.size(), 0, "R2 pending scoreboard items");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge pclk);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned e, w;
        repeat (3) @(posedge pclk);
        #1 presetn = 1'b1;

        // R1 reset state
        check(tmr_irq, 1'b0, "R1 irq after reset");
        expect_read(A_CTL,  32'h20,        "R1 control reset");
        expect_read(A_VAL,  32'hFFFF_FFFF, "R1 value reset");
        expect_read(A_LOAD, 32'h0,         "R1 load reset");
        expect_read(A_BG,   32'h0,         "R1 bgload reset");
        expect_read(A_RAW,  32'h0,         "R1 raw reset");
        expect_read(A_MSK,  32'h0,         "R1 masked reset");

        // R2 decode, read-back, tie-offs, uncommitted write
        check(pready, 1'b1, "R2 pready");
        check(pslverr, 1'b0, "R2 pslverr");
        apb_write(A_CTL, 32'h5E);
        expect_read(A_CTL, 32'h5E, "R2 control read-back");
        expect_read(A_CLR, 32'h0, "R2 clear reads zero");
        expect_read(8'h1C, 32'h0, "R2 unmapped reads zero");
        @(posedge pclk); #1;
        psel = 1'b1; pwrite = 1'b1; paddr = A_LOAD; pwdata = 32'h77;
        @(posedge pclk); #1;
        psel = 1'b0; pwrite = 1'b0;
        expect_read(A_LOAD, 32'h0, "R2 setup-only write ignored");

        // R3 direct load with timer stopped, 32-bit
        apb_write(A_LOAD, 32'h1234_5678);
        expect_read(A_VAL,  32'h1234_5678, "R3 load replaces value");
        expect_read(A_LOAD, 32'h1234_5678, "R3 load sets reload");
        expect_read(A_BG,   32'h1234_5678, "R2 bgload reads reload");

        // R4 background load leaves count; R6 stopped count frozen
        apb_write(A_BG, 32'h55);
        expect_read(A_VAL,  32'h1234_5678, "R4 bgload keeps value");
        expect_read(A_LOAD, 32'h55,        "R4 bgload sets reload");
        expect_read(A_VAL,  32'h1234_5678, "R6 value frozen while disabled");

        // R5 16-bit masking
        apb_write(A_CTL, 32'h00);
        apb_write(A_LOAD, 32'hABCD_1234);
        expect_read(A_VAL,  32'h1234, "R5 value masked to 16 bits");
        expect_read(A_LOAD, 32'h1234, "R5 reload masked to 16 bits");
        apb_write(A_BG, 32'hFFFF_0007);
        expect_read(A_BG, 32'h7, "R5 bgload masked to 16 bits");

        // R6 divider sweep (latency = divisor * (load+1))
        div_trial(32'h00, 32'd3, 4,   "R6 divide-by-1 latency");
        div_trial(32'h04, 32'd3, 64,  "R6 divide-by-16 latency");
        div_trial(32'h08, 32'd1, 512, "R6 divide-by-256 latency");
        div_trial(32'h0C, 32'd0, 256, "R6 code 11 acts as 256");

        // R7 one-shot overrides periodic; R8 status; R9 read/clear
        apb_write(A_CTL, IE | WIDE);
        apb_write(A_CLR, 32'h1);
        apb_write(A_LOAD, 32'd2);
        apb_write_at(A_CTL, EN | PER | IE | WIDE | ONE, e);
        expect_irq(e + 3, "R8 one-shot zero sets irq");
        wait_irq_done();
        expect_read(A_VAL, 32'h0, "R7 one-shot holds at zero");
        apb_write(A_CTL, IE | WIDE);
        expect_read(A_RAW, 32'h1, "R8 raw status set");
        expect_read(A_MSK, 32'h1, "R8 masked status set");
        expect_read(A_RAW, 32'h1, "R9 status read does not clear");
        expect_read(A_VAL, 32'h0, "R7 one-shot still at zero");
        check(tmr_irq, 1'b1, "R9 irq survives reads");
        apb_write(A_CLR, 32'h0);
        check(tmr_irq, 1'b0, "R9 clear with zero data drops irq");
        expect_read(A_RAW, 32'h0, "R9 raw cleared");
        expect_read(A_MSK, 32'h0, "R9 masked cleared");

        // R7 free-running 16-bit wrap; R8 mask off
        apb_write(A_CTL, 32'h00);
        apb_write(A_LOAD, 32'd1);
        apb_write(A_CTL, EN);
        apb_write(A_CTL, 32'h00);
        expect_read(A_VAL, 32'hFFFE, "R7 free-running wraps to 0xFFFF");
        expect_read(A_RAW, 32'h1, "R8 raw set with mask off");
        expect_read(A_MSK, 32'h0, "R8 masked low with mask off");
        check(tmr_irq, 1'b0, "R8 irq low with mask off");
        apb_write(A_CLR, 32'h1);

        // R4 mid-count background load keeps current period
        apb_write(A_CTL, IE | WIDE);
        apb_write(A_LOAD, 32'd40);
        apb_write_at(A_CTL, EN | PER | IE | WIDE, e);
        expect_irq(e + 41, "R4 current period unchanged by bgload");
        apb_write(A_BG, 32'd10);
        wait_irq_done();
        apb_write(A_CLR, 32'h1);
        expect_irq(e + 52, "R4 new period after reload");
        wait_irq_done();
        apb_write(A_CTL, IE | WIDE);
        apb_write(A_CLR, 32'h1);

        // R3 mid-count direct load restarts period
        apb_write(A_LOAD, 32'd40);
        apb_write_at(A_CTL, EN | PER | IE | WIDE, e);
        apb_write_at(A_LOAD, 32'd10, w);
        expect_irq(w + 11, "R3 load restarts count");
        wait_irq_done();
        apb_write(A_CLR, 32'h1);
        expect_irq(w + 22, "R7 periodic reload of new value");
        wait_irq_done();
        apb_write(A_CTL, IE | WIDE);
        apb_write(A_CLR, 32'h1);

        finish_run();
    end
endmodule